// File: doc/BRIEF.md
# Latched-Address One-Time-Programmable ROM

This block models a 2048-word by 8-bit read-only memory whose bits can be set once. A word address is captured into an internal register at the moment the active-low chip-enable input is seen to fall. All later reads and program operations use that captured address until chip enable falls again. The address pins may therefore carry other traffic, such as a shared address/data bus, while chip enable stays low. Inputs are sampled on a system clock, and enable transitions are found by comparing consecutive samples.

An active-low output-enable input gates the read bus separately from chip enable. A three-state bus is modelled as a data word plus a drive flag. When the flag is low the data word is forced to zero. The read and program paths are plain control and data pins with no valid/ready handshake, so there is no back-pressure. A read result simply appears on the cycle given in the requirements. The storage is a square bit matrix with 128 rows and 128 columns. An active-low program-mode input together with a program strobe ORs a data byte into the latched word. Bits only ever go from 0 to 1, and a reset returns the model to a blank device.

Top module: `otp_latched_rom`

## Requirements
- R1: The memory has 2048 independent 8-bit words selected by an 11-bit address. Address bits [10:4] pick one of 128 rows. Address bits [3:0] pick the column inside each data bit's group of 16 columns.
- R2: A clock edge at which `ce_n` is sampled low, after being sampled high at the previous edge, loads `addr` into the latched address. The latched address then holds until the next such falling transition.
- R3: When `ce_n` and `oe_n` are both sampled low at an edge that is not a capture edge, `rd_en` is 1 after that edge and `rd_data` is the word at the latched address. Data therefore appears one edge after the capture edge, or one edge after `oe_n` is first seen low, whichever is later.
- R4: An edge at which `ce_n` is low and `oe_n` is high leaves `rd_en` at 0.
- R5: An edge at which `ce_n` is high leaves `rd_en` at 0, whatever the value of `oe_n`.
- R6: After reset, every bit reads 0.
- R7: A program operation happens at an edge where `prog_n`=0, `prog_stb`=1 and `ce_n`=0, and that edge is not a capture edge. It ORs `prog_data` into the word at the latched address.
- R8: A program operation never clears a bit that is already 1. Programming 0x00 over a word leaves that word unchanged.
- R9: A strobe with `prog_n`=1, or with `ce_n`=1, leaves the array unchanged.
- R10: Changes on `addr` while `ce_n` stays low do not change the word that is read.
- R11: While `rd_en` is 0, `rd_data` is 0.
- R12: Reset clears `rd_en`, `rd_data` and the latched address to 0. A `ce_n` held low from reset is not treated as a falling transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip enable; a sampled fall captures the address |
| oe_n | input | 1 | Active-low output enable |
| prog_n | input | 1 | Active-low program mode; held high for normal reads |
| prog_stb | input | 1 | Program strobe, active high |
| addr | input | 11 | Word address inputs |
| prog_data | input | 8 | Bits to set during a program operation |
| rd_data | output | 8 | Read word, zero when not driven |
| rd_en | output | 1 | Drive flag standing in for the bus enable |

## Verification
A capture takes one edge, and the read data and drive flag are registered at the following edge. The bench therefore samples read data at the second falling clock edge after it lowers `ce_n`. Output-enable and chip-enable changes act one edge later, so each such check is taken at the next falling clock edge. A program strobe updates the array at its edge, and the new value is sampled at the edge after it. The bench drives all inputs and samples all outputs on falling clock edges, at exactly those cycle counts.

// File: rtl/otp_pkg.sv
package otp_pkg;
  // Sampled control pins, converted to active-high meaning.
  typedef struct packed {
    logic chip_on;
    logic out_on;
    logic prog_mode;
    logic strobe;
  } otp_ctl_t;
endpackage

// File: rtl/otp_addr_latch.sv
module otp_addr_latch #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              fall,
  output logic [ADDR_W-1:0] addr_lat
);
  logic ce_prev;

  // Reset to 0 so that an enable held low from reset is not a fall (R12).
  assign fall = ce_prev & ~ce_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_prev  <= 1'b0;
      addr_lat <= '0;
    end else begin
      ce_prev <= ce_n;
      if (fall) addr_lat <= addr;
    end
  end

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> (addr_lat == $past(addr)));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(addr_lat));
endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int ROW_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_lat,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_bits,
  output logic [DATA_W-1:0] rd_word
);
  localparam int COL_W    = ADDR_W - ROW_W;
  localparam int ROWS     = 1 << ROW_W;
  localparam int GROUP    = 1 << COL_W;
  localparam int ROW_BITS = DATA_W * GROUP;

  logic [ROW_BITS-1:0] rows [ROWS];
  logic [ROW_W-1:0]    row;
  logic [COL_W-1:0]    col;
  logic [ROW_BITS-1:0] row_sel;
  logic [ROW_BITS-1:0] set_mask;

  // R1: upper bits select the row, lower bits the column inside each group.
  assign row     = addr_lat[ADDR_W-1:COL_W];
  assign col     = addr_lat[COL_W-1:0];
  assign row_sel = rows[row];

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic [GROUP-1:0] grp;
    assign grp        = row_sel[b*GROUP +: GROUP];
    assign rd_word[b] = grp[col];
    assign set_mask[b*GROUP +: GROUP] = wr_bits[b] ? (GROUP'(1) << col) : '0;
  end

  // One-way update: bits are only ever ORed in (R7, R8).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) rows[r] <= '0;
    end else if (wr_en) begin
      rows[row] <= row_sel | set_mask;
    end
  end

  p_prog_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_word & $past(wr_bits)) == $past(wr_bits)));
  p_no_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_word & $past(rd_word)) == $past(rd_word)));
  p_idle_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (!$stable(addr_lat) || $stable(rd_word)));
endmodule

// File: rtl/otp_out_stage.sv
module otp_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_on,
  input  logic              out_on,
  input  logic              fall,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_en
);
  logic drive_next;

  // Enable truth table; the capture edge itself never drives stale data.
  assign drive_next = chip_on & out_on & ~fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en   <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_en   <= drive_next;
      rd_data <= drive_next ? rd_word : '0;
    end
  end

  p_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_on && out_on && !fall) |=> (rd_en && rd_data == $past(rd_word)));
  p_oe_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_on && !out_on) |=> !rd_en);
  p_ce_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_on |=> !rd_en);
  p_quiet_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0));
endmodule

// File: rtl/otp_latched_rom.sv
module otp_latched_rom
  import otp_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int ROW_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              prog_n,
  input  logic              prog_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] prog_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_en
);
  otp_ctl_t          ctl;
  logic              fall;
  logic              wr_en;
  logic [ADDR_W-1:0] addr_lat;
  logic [DATA_W-1:0] rd_word;

  assign ctl.chip_on   = ~ce_n;
  assign ctl.out_on    = ~oe_n;
  assign ctl.prog_mode = ~prog_n;
  assign ctl.strobe    = prog_stb;

  // R7, R9: commit only with program mode, strobe, chip on, and a settled address.
  assign wr_en = ctl.prog_mode & ctl.strobe & ctl.chip_on & ~fall;

  otp_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .addr(addr),
    .fall(fall), .addr_lat(addr_lat)
  );

  otp_fuse_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_W(ROW_W)) u_array (
    .clk(clk), .rst_n(rst_n), .addr_lat(addr_lat), .wr_en(wr_en),
    .wr_bits(prog_data), .rd_word(rd_word)
  );

  otp_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .chip_on(ctl.chip_on), .out_on(ctl.out_on),
    .fall(fall), .rd_word(rd_word), .rd_data(rd_data), .rd_en(rd_en)
  );

  p_prog_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_n || ce_n) |=> $stable(rd_word) || !$stable(addr_lat));
endmodule

// File: tb/sim_otp_latched_rom.sv
module sim_otp_latched_rom;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b0, oe_n = 1'b1, prog_n = 1'b1, prog_stb = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0]  prog_data = '0;
  logic [7:0]  rd_data;
  logic        rd_en;

  bit [7:0] ref_mem [2048];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  otp_latched_rom u0 (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
    .prog_n(prog_n), .prog_stb(prog_stb), .addr(addr), .prog_data(prog_data),
    .rd_data(rd_data), .rd_en(rd_en));

  function automatic logic [7:0] exp_word(input logic [10:0] a);
    return ref_mem[a];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Raise then lower ce_n with the given address; returns after the capture edge.
  task automatic capture(input logic [10:0] a, input logic oe_v);
    ce_n = 1'b1; tick();
    ce_n = 1'b0; addr = a; oe_n = oe_v; tick();
  endtask

  task automatic read_chk(input logic [10:0] a, input string req);
    capture(a, 1'b0);
    chk(!rd_en, {req, " not yet driven on capture edge"}, rd_en, 0);
    tick();
    chk(rd_en && rd_data == exp_word(a), req, rd_data, exp_word(a));
  endtask

  task automatic prog_op(input logic [10:0] a, input logic [7:0] w,
                         input logic pn, input logic cen);
    capture(a, 1'b1);
    prog_n = pn; prog_stb = 1'b1; ce_n = cen; prog_data = w; tick();
    prog_stb = 1'b0; prog_n = 1'b1; prog_data = '0;
    if (!pn && !cen) ref_mem[a] = ref_mem[a] | w;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] keep;
    void'($urandom(32'd4242));
    addr = 11'd5;
    tick(); tick();
    // R12: reset state of the outputs
    chk(!rd_en && rd_data == 8'h00, "R12 reset outputs", rd_data, 0);
    rst_n = 1'b1; tick();
    chk(!rd_en, "R12 ce held low from reset is not a capture", rd_en, 0);
    // R12: latched address is 0 after reset: program without any capture
    prog_n = 1'b0; prog_stb = 1'b1; prog_data = 8'hA5; tick();
    prog_n = 1'b1; prog_stb = 1'b0; prog_data = '0;
    ref_mem[0] = 8'hA5;
    oe_n = 1'b0; tick();
    chk(rd_en && rd_data == 8'hA5, "R12 latched address resets to 0", rd_data, 8'hA5);
    // R6: blank words read 0
    read_chk(11'd5, "R6 blank word");
    read_chk(11'h7FF, "R6 blank top word");
    // R1: neighbours in row and column are independent
    prog_op(11'h00F, 8'h3C, 1'b0, 1'b0);
    prog_op(11'h7F0, 8'hC1, 1'b0, 1'b0);
    prog_op(11'h010, 8'h81, 1'b0, 1'b0);
    read_chk(11'h00F, "R1 column 15 row 0");
    read_chk(11'h7F0, "R1 row 127 column 0");
    read_chk(11'h010, "R1 row 1 column 0");
    read_chk(11'h00E, "R1 adjacent column untouched");
    read_chk(11'h000, "R1 word 0 intact");
    // R7, R8: set more bits, then try to clear
    prog_op(11'h123, 8'hF0, 1'b0, 1'b0);
    prog_op(11'h123, 8'h0F, 1'b0, 1'b0);
    read_chk(11'h123, "R7 OR of two programs");
    prog_op(11'h123, 8'h00, 1'b0, 1'b0);
    read_chk(11'h123, "R8 zero program does not clear");
    // R9: strobe with program mode off, and with chip disabled
    prog_op(11'h200, 8'hFF, 1'b1, 1'b0);
    read_chk(11'h200, "R9 prog_n high ignored");
    prog_op(11'h201, 8'hFF, 1'b0, 1'b1);
    read_chk(11'h201, "R9 ce_n high ignored");
    // R10: address wiggle while enabled
    read_chk(11'h7F0, "R3 read before wiggle");
    keep = rd_data;
    addr = 11'h00F; tick();
    addr = 11'h555; tick();
    chk(rd_en && rd_data == keep, "R10 address change ignored", rd_data, keep);
    // R4, R11: output enable high
    oe_n = 1'b1; tick();
    chk(!rd_en, "R4 oe_n high disables", rd_en, 0);
    chk(rd_data == 8'h00, "R11 undriven data is zero", rd_data, 0);
    // R3: late output enable
    oe_n = 1'b0; tick();
    chk(rd_en && rd_data == keep, "R3 late oe_n drives next edge", rd_data, keep);
    // R5: chip off whatever oe_n
    ce_n = 1'b1; tick();
    chk(!rd_en && rd_data == 0, "R5 ce_n high with oe_n low", rd_data, 0);
    oe_n = 1'b1; tick();
    chk(!rd_en, "R5 ce_n high with oe_n high", rd_en, 0);
    // R2: capture holds across another cycle with new address pins
    capture(11'h010, 1'b0);
    addr = 11'h00F; tick(); tick();
    chk(rd_data == exp_word(11'h010), "R2 capture held", rd_data, exp_word(11'h010));
    // Random mix against the model (R3, R7, R8)
    for (int i = 0; i < 300; i++) begin
      logic [10:0] a;
      a = {4'($urandom_range(0, 15)), 7'($urandom_range(0, 3) * 5)};
      if ($urandom_range(0, 2) == 0)
        prog_op(a, 8'($urandom), 1'b0, 1'b0);
      else
        read_chk(a, "R3 random read");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule